// File: doc/BRIEF.md
# Event-Selectable Counter Bank

This block is a bank of 64-bit counters that a cache controller uses to count its own activity. Each counter is paired with a selector register. The selector names one of four event groups and holds a bitmask of events within that group. The counter then advances on every cycle in which at least one of the chosen events pulses. Each group delivers its events as a vector of single-cycle pulses. A counter can therefore track the union of several events from one group. A selector of zero parks its counter.

Software reaches the selectors and counters through a 32-bit register port. Requests use a valid/ready handshake and read data comes back on a valid/ready response channel. A request is accepted in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low only while a read response is still waiting for `rsp_ready`. Writes produce no response. Each 64-bit register is seen as two 32-bit words. Software normally clears a counter and then programs its selector. Both may be read or written at any time while counting goes on.

Top module: `perf_counter_bank`

## Requirements
- R1: Byte offsets: selector n lives at 0x2000 + 8n and counter n at 0x3000 + 8n. Offset bit 2 picks the high word (1) or the low word (0). Offset bits 1:0 are ignored.
- R2: A selector stores bits 27:0 of the written low word: bits 7:0 are the group number and bit 8+k enables event k. On read-back, bits above 27 and the whole high word read as zero. Writes to a selector's high word are ignored.
- R3: Groups 1, 2, 3 and 4 carry 20, 19, 14 and 1 events. A group number of 0, or of 5 and above, never advances the counter. Mask bits at or above the chosen group's size have no effect.
- R4: A counter rises by exactly one in a cycle where any enabled event of its group pulses, however many pulse together. Otherwise it holds its value.
- R5: A write to one word of a counter replaces that word and leaves the other word unchanged. It also cancels any increment due in that same cycle.
- R6: A counter at all ones that increments becomes zero.
- R7: Reset clears every selector and every counter, and leaves no response pending.
- R8: A read of an offset that maps to no register, including an index at or above the counter count, returns zero. A write to such an offset changes nothing.
- R9: `req_ready` equals `!rsp_valid || rsp_ready`. A read accepted at one clock edge raises `rsp_valid` after that edge. Its data is the register value as it stood before that edge's updates. The response holds steady until `rsp_ready` is seen high.
- R10: A selector write applies to counting from the cycle after the write. Events in the write cycle are judged against the old selector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 14 | Byte offset within the block |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Consumer takes read data |
| rsp_rdata | output | 32 | Read data |
| ev_grp1 | input | 20 | Event pulses, group 1 |
| ev_grp2 | input | 19 | Event pulses, group 2 |
| ev_grp3 | input | 14 | Event pulses, group 3 |
| ev_grp4 | input | 1 | Event pulse, group 4 |

## Verification
The bench builds the bank with six counters rather than 64. This keeps a full sweep of every selector and counter short. It also leaves indices 6 and 7 decoded by the address bits yet beyond the bank, so the out-of-range index path of R8 is reachable. Counters are preloaded near all ones, so wrap-around is reached in a few cycles instead of after 2^64 events. Back-pressure on `rsp_ready`, both directed and random, exercises response holding and the `req_ready` rule.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
  localparam int CNT_W    = 64;
  localparam int WORD_W   = 32;
  localparam int ADDR_W   = 14;
  localparam int GRP_W    = 8;
  localparam int G1_EV    = 20;
  localparam int G2_EV    = 19;
  localparam int G3_EV    = 14;
  localparam int G4_EV    = 1;
  localparam int MAX_EV   = G1_EV;
  localparam int SEL_W    = GRP_W + MAX_EV;
  localparam int IDX_W    = 9;

  typedef enum logic [1:0] {
    RGN_NONE0 = 2'b00,
    RGN_NONE1 = 2'b01,
    RGN_SEL   = 2'b10,
    RGN_CNT   = 2'b11
  } region_e;
endpackage

// File: rtl/pcb_event_match.sv
module pcb_event_match
  import pcb_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  input  logic [G1_EV-1:0] ev1,
  input  logic [G2_EV-1:0] ev2,
  input  logic [G3_EV-1:0] ev3,
  input  logic [G4_EV-1:0] ev4,
  output logic             hit
);
  logic [MAX_EV-1:0] mask;
  logic [GRP_W-1:0]  grp;

  assign mask = sel[SEL_W-1:GRP_W];
  assign grp  = sel[GRP_W-1:0];

  always_comb begin
    unique case (grp)
      8'd1:    hit = |(mask[G1_EV-1:0] & ev1);
      8'd2:    hit = |(mask[G2_EV-1:0] & ev2);
      8'd3:    hit = |(mask[G3_EV-1:0] & ev3);
      8'd4:    hit = |(mask[G4_EV-1:0] & ev4);
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/pcb_counter.sv
module pcb_counter
  import pcb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [WORD_W-1:0] wdata,
  output logic [CNT_W-1:0]  cnt_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (wr_lo) begin
      cnt_q[WORD_W-1:0] <= wdata;
    end else if (wr_hi) begin
      cnt_q[CNT_W-1:WORD_W] <= wdata;
    end else if (inc) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !wr_lo && !wr_hi) |=> cnt_q == $past(cnt_q) + 64'd1);
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !wr_lo && !wr_hi) |=> $stable(cnt_q));
  a_r5_lo_keeps_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !wr_hi) |=> cnt_q[CNT_W-1:WORD_W] == $past(cnt_q[CNT_W-1:WORD_W]));
  a_r5_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && inc) |=> cnt_q[WORD_W-1:0] == $past(wdata));
  a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !wr_lo && !wr_hi && cnt_q == '1) |=> cnt_q == '0);
endmodule

// File: rtl/pcb_regif.sv
module pcb_regif
  import pcb_pkg::*;
#(
  parameter int N_CTR = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic                        req_write,
  input  logic [ADDR_W-1:0]           req_addr,
  output logic                        rsp_valid,
  input  logic                        rsp_ready,
  output logic [WORD_W-1:0]           rsp_rdata,
  input  logic [N_CTR-1:0][SEL_W-1:0] sel_q,
  input  logic [N_CTR-1:0][CNT_W-1:0] cnt_q,
  output logic [N_CTR-1:0]            sel_we,
  output logic [N_CTR-1:0]            cnt_we_lo,
  output logic [N_CTR-1:0]            cnt_we_hi
);
  logic              accept;
  logic              is_wr;
  region_e           rgn;
  logic [IDX_W-1:0]  idx;
  logic              hi_word;
  logic [WORD_W-1:0] rd_val;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign is_wr     = accept && req_write;
  assign rgn       = region_e'(req_addr[ADDR_W-1:ADDR_W-2]);
  assign idx       = req_addr[IDX_W+2:3];
  assign hi_word   = req_addr[2];

  always_comb begin
    sel_we    = '0;
    cnt_we_lo = '0;
    cnt_we_hi = '0;
    rd_val    = '0;
    for (int i = 0; i < N_CTR; i++) begin
      if (idx == IDX_W'(i)) begin
        if (rgn == RGN_SEL && !hi_word) begin
          sel_we[i] = is_wr;
          rd_val    = WORD_W'(sel_q[i]);
        end
        if (rgn == RGN_CNT) begin
          cnt_we_lo[i] = is_wr && !hi_word;
          cnt_we_hi[i] = is_wr && hi_word;
          rd_val       = hi_word ? cnt_q[i][CNT_W-1:WORD_W] : cnt_q[i][WORD_W-1:0];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (accept && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_val;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_rdata));
  a_r9_read_gives_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid);
  a_r1_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_we, cnt_we_lo, cnt_we_hi}));
endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank
  import pcb_pkg::*;
#(
  parameter int N_CTR = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [WORD_W-1:0]     req_wdata,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [WORD_W-1:0]     rsp_rdata,
  input  logic [G1_EV-1:0]      ev_grp1,
  input  logic [G2_EV-1:0]      ev_grp2,
  input  logic [G3_EV-1:0]      ev_grp3,
  input  logic [G4_EV-1:0]      ev_grp4
);
  logic [N_CTR-1:0][SEL_W-1:0] sel_q;
  logic [N_CTR-1:0][CNT_W-1:0] cnt_q;
  logic [N_CTR-1:0]            sel_we;
  logic [N_CTR-1:0]            cnt_we_lo;
  logic [N_CTR-1:0]            cnt_we_hi;
  logic [N_CTR-1:0]            hit;

  pcb_regif #(.N_CTR(N_CTR)) u_regif (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_rdata (rsp_rdata),
    .sel_q     (sel_q),
    .cnt_q     (cnt_q),
    .sel_we    (sel_we),
    .cnt_we_lo (cnt_we_lo),
    .cnt_we_hi (cnt_we_hi)
  );

  for (genvar i = 0; i < N_CTR; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_q[i] <= '0;
      end else if (sel_we[i]) begin
        sel_q[i] <= req_wdata[SEL_W-1:0];
      end
    end

    pcb_event_match u_match (
      .sel (sel_q[i]),
      .ev1 (ev_grp1),
      .ev2 (ev_grp2),
      .ev3 (ev_grp3),
      .ev4 (ev_grp4),
      .hit (hit[i])
    );

    pcb_counter u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (hit[i]),
      .wr_lo (cnt_we_lo[i]),
      .wr_hi (cnt_we_hi[i]),
      .wdata (req_wdata),
      .cnt_q (cnt_q[i])
    );

    a_r3_bad_group_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_we_lo[i] && !cnt_we_hi[i] &&
       (sel_q[i][GRP_W-1:0] == 8'd0 || sel_q[i][GRP_W-1:0] > 8'd4)) |=> $stable(cnt_q[i]));
    a_r10_sel_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      sel_we[i] |=> sel_q[i] == $past(req_wdata[SEL_W-1:0]));
  end
endmodule

// File: tb/test_perf_counter_bank.sv
module test_perf_counter_bank;
  localparam int N = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [13:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic [19:0] ev_grp1 = '0;
  logic [18:0] ev_grp2 = '0;
  logic [13:0] ev_grp3 = '0;
  logic [0:0]  ev_grp4 = '0;

  perf_counter_bank #(.N_CTR(N)) i_perf_counter_bank (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .ev_grp1(ev_grp1), .ev_grp2(ev_grp2), .ev_grp3(ev_grp3), .ev_grp4(ev_grp4)
  );

  always #2 clk = ~clk;

  int          n_chk = 0;
  int          n_bad = 0;
  bit          done  = 0;
  string       cur   = "R7";
  logic [63:0] m_cnt [8];
  logic [27:0] m_sel [8];
  logic        m_rv  = 1'b0;
  logic [31:0] m_rd  = '0;

  function automatic logic [13:0] sa(int i, bit hi);
    return 14'(32'h2000 + i * 8 + (hi ? 4 : 0));
  endfunction
  function automatic logic [13:0] ca(int i, bit hi);
    return 14'(32'h3000 + i * 8 + (hi ? 4 : 0));
  endfunction

  function automatic bit ev_hit(logic [27:0] s, logic [19:0] e1, logic [18:0] e2,
                                logic [13:0] e3, logic e4);
    logic [19:0] m;
    m = s[27:8];
    case (int'(s[7:0]))
      1: return (m & e1) != 0;
      2: return (m[18:0] & e2) != 0;
      3: return (m[13:0] & e3) != 0;
      4: return m[0] & e4;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] rd_model(logic [13:0] a);
    int idx;
    idx = int'(a[11:3]);
    if (idx >= N) return 32'h0;
    if (a[13:12] == 2'b10) return a[2] ? 32'h0 : {4'h0, m_sel[idx]};
    if (a[13:12] == 2'b11) return a[2] ? m_cnt[idx][63:32] : m_cnt[idx][31:0];
    return 32'h0;
  endfunction

  task automatic chk(bit ok, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", cur, what, act, exp);
    end
  endtask

  task automatic cyc(bit v, bit w, logic [13:0] a, logic [31:0] d,
                     logic [19:0] e1, logic [18:0] e2, logic [13:0] e3, logic e4, bit rr);
    bit mready, fire;
    req_valid = v; req_write = w; req_addr = a; req_wdata = d;
    ev_grp1 = e1; ev_grp2 = e2; ev_grp3 = e3; ev_grp4 = e4; rsp_ready = rr;
    #1;
    mready = !m_rv || rr;
    chk(req_ready == mready, "req_ready", 64'(req_ready), 64'(mready));
    chk(rsp_valid == m_rv, "rsp_valid", 64'(rsp_valid), 64'(m_rv));
    if (m_rv) chk(rsp_rdata == m_rd, "rsp_rdata", 64'(rsp_rdata), 64'(m_rd));
    fire = v && mready;
    if (fire && !w) begin
      m_rd = rd_model(a);
      m_rv = 1'b1;
    end else if (rr) begin
      m_rv = 1'b0;
    end
    for (int i = 0; i < N; i++) begin
      bit wl, wh;
      wl = fire && w && a[13:12] == 2'b11 && int'(a[11:3]) == i && !a[2];
      wh = fire && w && a[13:12] == 2'b11 && int'(a[11:3]) == i && a[2];
      if (wl) m_cnt[i][31:0] = d;
      else if (wh) m_cnt[i][63:32] = d;
      else if (ev_hit(m_sel[i], e1, e2, e3, e4)) m_cnt[i] = m_cnt[i] + 64'd1;
    end
    if (fire && w && a[13:12] == 2'b10 && !a[2] && int'(a[11:3]) < N)
      m_sel[int'(a[11:3])] = d[27:0];
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [13:0] a, logic [31:0] d);
    cyc(1, 1, a, d, '0, '0, '0, 1'b0, 1);
  endtask
  task automatic rd(logic [13:0] a);
    cyc(1, 0, a, '0, '0, '0, '0, 1'b0, 1);
  endtask
  task automatic ev(logic [19:0] e1, logic [18:0] e2, logic [13:0] e3, logic e4);
    cyc(0, 0, '0, '0, e1, e2, e3, e4, 1);
  endtask
  task automatic dump();
    for (int i = 0; i < N; i++) begin
      rd(ca(i, 0)); rd(ca(i, 1)); rd(sa(i, 0));
    end
    ev('0, '0, '0, 1'b0);
  endtask

  initial begin
    #(4 * 200000);
    $display("FAIL watchdog: actual running expected finished");
    n_chk++; n_bad++;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin m_cnt[i] = '0; m_sel[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    cur = "R7";  dump();

    cur = "R2";
    wr(sa(0, 0), 32'hFFFF_FF01);
    wr(sa(0, 1), 32'hDEAD_BEEF);
    rd(sa(0, 0)); rd(sa(0, 1)); rd(14'(32'h2001)); rd(14'(32'h2003));
    cur = "R1";
    wr(ca(2, 0), 32'h1234_5678); wr(ca(2, 1), 32'h9ABC_DEF0);
    rd(ca(2, 0)); rd(ca(2, 1)); rd(14'(32'h3012)); dump();

    cur = "R4";
    for (int i = 0; i < N; i++) begin wr(ca(i, 0), 0); wr(ca(i, 1), 0); end
    wr(sa(0, 0), 32'h0000_0901);
    wr(sa(1, 0), 32'h0000_0402);
    wr(sa(2, 0), 32'h0020_0003);
    wr(sa(3, 0), 32'h0000_0104);
    ev(20'h00001, '0, '0, 1'b0);
    ev(20'h00009, 19'h4, 14'h2000, 1'b1);
    ev(20'h00002, 19'h3, 14'h1000, 1'b0);
    ev(20'hFFFFF, 19'h7FFFF, 14'h3FFF, 1'b1);
    dump();

    cur = "R3";
    wr(sa(4, 0), 32'hFFFF_FF00);
    wr(sa(5, 0), 32'hFFFF_FF05);
    wr(sa(3, 0), 32'h0000_0204);
    wr(sa(1, 0), 32'h0008_0002);
    wr(sa(2, 0), 32'h0040_0003);
    for (int k = 0; k < 5; k++) ev(20'hFFFFF, 19'h7FFFF, 14'h3FFF, 1'b1);
    dump();

    cur = "R5";
    wr(sa(0, 0), 32'h0000_0101);
    cyc(1, 1, ca(0, 0), 32'h0000_0050, 20'h1, '0, '0, 1'b0, 1);
    cyc(1, 1, ca(0, 1), 32'h0000_0007, 20'h1, '0, '0, 1'b0, 1);
    ev(20'h1, '0, '0, 1'b0);
    dump();

    cur = "R6";
    wr(ca(0, 0), 32'hFFFF_FFFE); wr(ca(0, 1), 32'hFFFF_FFFF);
    ev(20'h1, '0, '0, 1'b0); ev(20'h1, '0, '0, 1'b0); ev(20'h1, '0, '0, 1'b0);
    dump();

    cur = "R8";
    wr(sa(6, 0), 32'h0000_0101); wr(ca(7, 0), 32'hAAAA_5555);
    wr(14'h1000, 32'h1111_1111); wr(14'h0008, 32'h2222_2222);
    rd(sa(6, 0)); rd(ca(7, 0)); rd(14'h1000); rd(14'h0008); rd(ca(N, 1));
    dump();

    cur = "R9";
    cyc(1, 0, ca(0, 0), '0, 20'h1, '0, '0, 1'b0, 0);
    cyc(1, 0, ca(1, 0), '0, 20'h1, '0, '0, 1'b0, 0);
    cyc(1, 1, ca(3, 0), 32'h77, 20'h1, '0, '0, 1'b0, 0);
    cyc(1, 0, ca(1, 0), '0, 20'h1, '0, '0, 1'b0, 1);
    cyc(1, 0, ca(3, 0), '0, '0, '0, '0, 1'b0, 1);
    cyc(0, 0, '0, '0, '0, '0, '0, 1'b0, 1);

    cur = "R10";
    wr(ca(5, 0), 0);
    cyc(1, 1, sa(5, 0), 32'h0000_0101, 20'h1, '0, '0, 1'b0, 1);
    ev(20'h1, '0, '0, 1'b0);
    cyc(1, 1, sa(5, 0), 32'h0, 20'h1, '0, '0, 1'b0, 1);
    ev(20'h1, '0, '0, 1'b0);
    rd(ca(5, 0)); ev('0, '0, '0, 1'b0);

    cur = "R4";
    for (int k = 0; k < 4000; k++) begin
      logic [13:0] a;
      int idx;
      idx = int'($urandom_range(0, 7));
      a = ($urandom_range(0, 1) == 0) ? sa(idx, $urandom_range(0, 1) == 1)
                                      : ca(idx, $urandom_range(0, 1) == 1);
      if ($urandom_range(0, 9) == 0) a = 14'($urandom_range(0, 16383));
      cyc($urandom_range(0, 2) != 0, $urandom_range(0, 3) == 0, a,
          ($urandom_range(0, 1) == 0) ? {24'h0, 8'($urandom_range(0, 5))} | (32'($urandom) & 32'h0FFF_FF00)
                                      : 32'($urandom),
          20'($urandom) & 20'($urandom), 19'($urandom) & 19'($urandom),
          14'($urandom) & 14'($urandom), 1'($urandom), $urandom_range(0, 3) != 0);
    end
    dump();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule